// File: doc/BRIEF.md
# Antenna Duty-Cycle Peak Regulator

This block generates the gate enables for the half-bridge that drives a resonant low-frequency antenna. It runs on a sub-clock of 32 ticks per carrier period. A carrier half-period is therefore 16 ticks, and the duty cycle is counted in sixteenths of it. The duty cycle is the number of ticks the high side is on in each carrier period, divided by the half-period.

Every burst opens at half duty. While the antenna peak stays below the reference, the duty rises in coarse steps and reaches the full half-period within three carrier cycles. When the peak comparator reports a value above the reference, the duty falls by one step per cycle. A higher supply voltage therefore settles at a lower duty. When the envelope overshoots the reference by 20%, the whole next high-side pulse is dropped and the duty also falls by one step.

The two comparator flags are taken once per carrier period, at its last tick. A status word reports the duty currently in force.

Top module: `antenna_duty_regulator`

## Requirements
- R1: While reset is asserted, and on release with the enable low, both gate outputs are low and the duty status reads 8 (sixteenths).
- R2: During a carrier period of duty D, let the tick index run from 0 to 31 from the first tick of that period. The high-side gate is on for exactly D ticks, at indices 1 to D. The low-side gate is on at indices D+2 to 31, which is 30-D ticks. The duty status gives D as an unsigned count from 2 to 16.
- R3: The first carrier period after the enable rises uses a duty of 8.
- R4: If both flags are low at the last tick of a period, the next period's duty is the current duty plus 3, capped at 16. The sequence is 8, 11, 14, 16.
- R5: If only the above-reference flag is high at the last tick, the next duty is the current duty minus 1, never below 2.
- R6: If the above-reference-plus-20% flag is high at the last tick, the high-side gate stays off for the whole next period and the duty drops by 1. This flag takes priority over the other one. The low side keeps its normal pattern during the skipped period.
- R7: Flag values present at any tick other than the last one of a period have no effect on the duty or on pulse skipping.
- R8: The two gates are never on together. Each one turns on only after at least one tick in which the other was off.
- R9: A tick after the enable is sampled low, both gates are low, the duty status is back to 8, any pending skip is cleared, and the next enable starts a fresh period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-clock, 32 ticks per carrier period |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Burst active; low forces both gates off |
| aboveRef | input | 1 | Peak current above the reference |
| aboveRefPlus20 | input | 1 | Peak current more than 20% above the reference |
| hsGate | output | 1 | High-side gate enable |
| lsGate | output | 1 | Low-side gate enable |
| dutyLevel | output | 5 | Duty in force, in sixteenths of the half-period |

## Verification
A gate value for tick index k is registered at the edge of that tick, so it becomes visible just after that edge. The bench's k-th sample after the enable edge therefore belongs to index k of the period. The bench holds each period's flags from the period's start through its last edge. It then reads the duty status after the 32nd sample, because the new duty is registered on that last edge. Pulse counts are compared for the period that follows. Disable is checked one tick after the enable falls, and reset is checked before the first enabled edge.

// File: rtl/adr_pkg.sv
package adr_pkg;
  typedef struct packed {
    logic active;     // burst enabled this tick
    logic periodEnd;  // last tick of a carrier period: sample flags
    logic reload;     // enable low: restore start-of-burst state
  } adrStrobe_t;
endpackage

// File: rtl/adr_ctrl.sv
module adr_ctrl
  import adr_pkg::*;
#(
  parameter int PERIOD = 32,
  localparam int PW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  output adrStrobe_t    strobe,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] phaseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseQ <= '0;
    else if (!enable)         phaseQ <= '0;
    else if (phaseQ == LAST)  phaseQ <= '0;
    else                      phaseQ <= phaseQ + PW'(1);
  end

  always_comb begin
    strobe.active    = enable;
    strobe.periodEnd = enable && (phaseQ == LAST);
    strobe.reload    = !enable;
  end

  assign phase = phaseQ;

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (phaseQ == '0)); // R9

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && phaseQ == LAST) |=> (phaseQ == '0)); // R2
endmodule

// File: rtl/adr_datapath.sv
module adr_datapath
  import adr_pkg::*;
#(
  parameter int PERIOD    = 32,
  parameter int DUTY_MIN  = 2,
  parameter int RAMP_STEP = 3,
  parameter int DOWN_STEP = 1,
  localparam int PW   = $clog2(PERIOD),
  localparam int HALF = PERIOD / 2,
  localparam int DW   = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  adrStrobe_t    strobe,
  input  logic [PW-1:0] phase,
  input  logic          aboveRef,
  input  logic          aboveRef20,
  output logic          hsOn,
  output logic          lsOn,
  output logic [DW-1:0] duty
);
  localparam logic [DW:0]   HALF_W = (DW+1)'(HALF);
  localparam logic [DW:0]   MIN_W  = (DW+1)'(DUTY_MIN);
  localparam logic [DW:0]   RAMP_W = (DW+1)'(RAMP_STEP);
  localparam logic [DW:0]   DOWN_W = (DW+1)'(DOWN_STEP);
  localparam logic [DW-1:0] INIT_D = DW'(HALF / 2);

  logic [DW-1:0] dutyQ, dutyNext, upDuty, downDuty;
  logic [DW:0]   upSum;
  logic          skipQ;
  logic [PW:0]   phaseExt, dutyExt, lsStart;
  logic          hsNext, lsNext;

  // duty update rule, applied once per carrier period
  always_comb begin
    upSum    = {1'b0, dutyQ} + RAMP_W;
    upDuty   = (upSum > HALF_W) ? HALF_W[DW-1:0] : upSum[DW-1:0];
    downDuty = ({1'b0, dutyQ} <= (MIN_W + DOWN_W)) ? MIN_W[DW-1:0]
                                                   : dutyQ - DOWN_W[DW-1:0];
    if (aboveRef20 || aboveRef) dutyNext = downDuty;
    else                        dutyNext = upDuty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyQ <= INIT_D;
      skipQ <= 1'b0;
    end else if (strobe.reload) begin
      dutyQ <= INIT_D;
      skipQ <= 1'b0;
    end else if (strobe.periodEnd) begin
      dutyQ <= dutyNext;
      skipQ <= aboveRef20;
    end
  end

  // gate pattern: high side at 1..D, dead tick, low side at D+2..PERIOD-1, dead tick at 0
  always_comb begin
    phaseExt = {1'b0, phase};
    dutyExt  = (PW+1)'(dutyQ);
    lsStart  = dutyExt + (PW+1)'(2);
    hsNext   = strobe.active && !skipQ &&
               (phaseExt >= (PW+1)'(1)) && (phaseExt <= dutyExt);
    lsNext   = strobe.active && (phaseExt >= lsStart);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsOn <= 1'b0;
      lsOn <= 1'b0;
    end else begin
      hsOn <= hsNext;
      lsOn <= lsNext;
    end
  end

  assign duty = dutyQ;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(hsOn && lsOn)); // R8

  AST_DEAD_BEFORE_HS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsOn) |-> !$past(lsOn)); // R8

  AST_DEAD_BEFORE_LS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsOn) |-> !$past(hsOn)); // R8

  AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, dutyQ} >= MIN_W) && ({1'b0, dutyQ} <= HALF_W)); // R5

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && !strobe.periodEnd) |=> $stable(dutyQ)); // R7

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    skipQ |=> !hsOn); // R6

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (dutyQ == INIT_D && !hsOn && !lsOn && !skipQ)); // R9
endmodule

// File: rtl/antenna_duty_regulator.sv
module antenna_duty_regulator #(
  parameter int PERIOD    = 32,
  parameter int DUTY_MIN  = 2,
  parameter int RAMP_STEP = 3,
  parameter int DOWN_STEP = 1,
  localparam int PW = $clog2(PERIOD),
  localparam int DW = $clog2(PERIOD / 2 + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          aboveRef,
  input  logic          aboveRefPlus20,
  output logic          hsGate,
  output logic          lsGate,
  output logic [DW-1:0] dutyLevel
);
  adr_pkg::adrStrobe_t strobe;
  logic [PW-1:0]       phase;

  adr_ctrl #(.PERIOD(PERIOD)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .strobe (strobe),
    .phase  (phase)
  );

  adr_datapath #(
    .PERIOD    (PERIOD),
    .DUTY_MIN  (DUTY_MIN),
    .RAMP_STEP (RAMP_STEP),
    .DOWN_STEP (DOWN_STEP)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .phase      (phase),
    .aboveRef   (aboveRef),
    .aboveRef20 (aboveRefPlus20),
    .hsOn       (hsGate),
    .lsOn       (lsGate),
    .duty       (dutyLevel)
  );
endmodule

// File: tb/antenna_duty_regulator_tb.sv
module antenna_duty_regulator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 32;
  localparam int NROWS = 12;
  // row: aboveRef, aboveRef20, duty of this period, skipped, duty after
  localparam int VEC[NROWS][5] = '{
    '{0,0,8,0,11},  '{0,0,11,0,14}, '{0,0,14,0,16}, '{0,0,16,0,16},
    '{1,0,16,0,15}, '{1,0,15,0,14}, '{0,1,14,0,13}, '{0,0,13,1,16},
    '{1,0,16,0,15}, '{1,1,15,0,14}, '{1,0,14,1,13}, '{0,0,13,0,16}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic aboveRef = 1'b0;
  logic aboveRefPlus20 = 1'b0;
  logic hsGate, lsGate;
  logic [4:0] dutyLevel;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic prevHs = 1'b0;
  logic prevLs = 1'b0;
  int hsCnt, lsCnt, hazards;

  always #(CLK_PERIOD/2) clk = ~clk;

  antenna_duty_regulator dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .aboveRef(aboveRef),
    .aboveRefPlus20(aboveRefPlus20), .hsGate(hsGate), .lsGate(lsGate),
    .dutyLevel(dutyLevel)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sampleTick();
    @(posedge clk);
    @(negedge clk);
    if (hsGate) hsCnt++;
    if (lsGate) lsCnt++;
    if (hsGate && lsGate) hazards++;
    if (hsGate && !prevHs && prevLs) hazards++;
    if (lsGate && !prevLs && prevHs) hazards++;
    prevHs = hsGate;
    prevLs = lsGate;
  endtask

  // one carrier period; flags may change after glitchTicks ticks
  task automatic runPeriod(input logic a, input logic a20,
                           input int glitchTicks, input logic ga, input logic ga20);
    hsCnt = 0; lsCnt = 0; hazards = 0;
    for (int t = 0; t < TICKS; t++) begin
      if (t < glitchTicks) begin aboveRef = ga; aboveRefPlus20 = ga20; end
      else begin aboveRef = a; aboveRefPlus20 = a20; end
      sampleTick();
    end
    check("R8 overlap/dead-tick", hazards, 0);
  endtask

  task automatic startBurst();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    prevHs = 1'b0; prevLs = 1'b0;
    enable = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 hsGate in reset", int'(hsGate), 0);
    check("R1 lsGate in reset", int'(lsGate), 0);
    check("R1 duty in reset", int'(dutyLevel), 8);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 hsGate idle", int'(hsGate), 0);
    check("R1 duty idle", int'(dutyLevel), 8);

    // table walk: R2 R3 R4 R5 R6
    startBurst();
    for (int r = 0; r < NROWS; r++) begin
      runPeriod(VEC[r][0][0], VEC[r][1][0], 0, 1'b0, 1'b0);
      check($sformatf("R2/R6 hs ticks row %0d", r), hsCnt, VEC[r][3] != 0 ? 0 : VEC[r][2]);
      check($sformatf("R2 ls ticks row %0d", r), lsCnt, 30 - VEC[r][2]);
      check($sformatf("R4/R5/R6 duty after row %0d", r), int'(dutyLevel), VEC[r][4]);
    end

    // R9 disable mid-period
    runPeriod(1'b0, 1'b0, 0, 1'b0, 1'b0);
    repeat (5) sampleTick();
    @(negedge clk);
    enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9 hs low after disable", int'(hsGate), 0);
    check("R9 ls low after disable", int'(lsGate), 0);
    check("R9 duty reload", int'(dutyLevel), 8);

    // R9 pending skip cleared, R3 restart at 8
    startBurst();
    runPeriod(1'b0, 1'b1, 0, 1'b0, 1'b0);
    startBurst();
    runPeriod(1'b0, 1'b0, 0, 1'b0, 1'b0);
    check("R3 first period duty 8 after restart", hsCnt, 8);
    check("R9 skip cleared by disable", int'(dutyLevel), 11);

    // R7 flags away from the last tick are ignored
    startBurst();
    runPeriod(1'b0, 1'b0, 20, 1'b1, 1'b1);
    check("R7 duty ignores mid-period flags", int'(dutyLevel), 11);
    runPeriod(1'b0, 1'b0, 0, 1'b0, 1'b0);
    check("R7 no skip from mid-period flag", hsCnt, 11);

    // R5 floor at 2
    startBurst();
    for (int p = 0; p < 9; p++) runPeriod(1'b1, 1'b0, 0, 1'b0, 1'b0);
    check("R5 duty floor", int'(dutyLevel), 2);
    check("R5 hs ticks at floor", hsCnt, 2);
    check("R2 ls ticks at floor", lsCnt, 28);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule